// File: doc/BRIEF.md
# Thread Fetch Sequencer

This block holds the fetch-side control state of every hardware thread in a multithreaded front end. For each thread it keeps four sticky stall flags, one per downstream stage (decode, rename, execute, commit). Each stage raises its flag with a block pulse and drops it with an unblock pulse. The block also holds a fetch PC and next-PC per thread and a state register that follows the thread through cache requests, retries, responses, pending traps and quiesce.

Redirect requests come from commit and from decode, and the reorder buffer can report that it is still squashing. These are resolved per thread by a fixed priority. A redirect loads the target into the PC and the target plus the instruction size into the next-PC. The thread then spends one cycle in the squashing state before it returns to running.

Two summary outputs are provided. One marks any cycle in which some thread changed state. The other says whether the fetch stage as a whole has work to do. All outputs are registered and reflect the inputs sampled at the previous rising clock edge.

Top module: `thread_fetch_seq`

## Requirements
- R1: After reset every thread is running (code 0). PC reads `RESET_PC` and next-PC reads `RESET_PC` + 4. The status-changed flag and the stage-active flag both read 0.
- R2: A block pulse from a stage sets that stage's flag for the thread. The flag stays set with no further pulses, and it holds a running thread in blocked (code 3) from the next cycle. An unblock pulse clears the flag, and with no flag left set the thread returns to running in the following cycle.
- R3: The four stage flags of a thread are independent. The thread stays blocked until every flag that was raised has been released.
- R4: A commit redirect wins over every other request in the same cycle. On the next cycle the thread is squashing (code 2), PC equals the commit target and next-PC equals the target plus 4. This applies in any state, including waiting for a response.
- R5: With no commit redirect, a reorder-buffer-squashing indication puts the thread in squashing and leaves PC unchanged. The thread stays in squashing for as long as the indication is held.
- R6: A decode redirect loads its target and enters squashing when the thread is not already squashing. It has no effect on PC while the thread is squashing.
- R7: A thread in squashing with no new redirect or reorder-buffer indication leaves squashing after exactly one cycle. It goes to blocked if any stall flag is set, and to running otherwise.
- R8: Stall flags do not move a thread that waits for a response (code 7). When the response arrives, the thread goes to blocked if a flag is set and to access-complete (code 8) otherwise. From access-complete it moves to running on a fetch-opportunity pulse.
- R9: From running, an issued request moves the thread to waiting for a response, and a refused request moves it to waiting for retry (code 6). A retry acceptance then moves it from waiting for retry to waiting for a response.
- R10: A quiesce pulse moves a running thread to quiesce-pending (code 5), and a fault pulse moves it to trap-pending (code 4). Neither state reacts to stall flags. Only a wake pulse (to running) or a redirect (to squashing) leaves either state.
- R11: The status-changed flag is 1 exactly in the cycle after an edge at which at least one thread's state changed.
- R12: The stage-active flag is 1 when at least one thread whose active-mask bit is set is running, squashing or access-complete. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_active_i | input | NT | Mask of threads taking part in the fetch schedule |
| blk_dec_i | input | NT | Decode block pulse per thread |
| unblk_dec_i | input | NT | Decode unblock pulse per thread |
| blk_ren_i | input | NT | Rename block pulse per thread |
| unblk_ren_i | input | NT | Rename unblock pulse per thread |
| blk_exe_i | input | NT | Execute block pulse per thread |
| unblk_exe_i | input | NT | Execute unblock pulse per thread |
| blk_cmt_i | input | NT | Commit block pulse per thread |
| unblk_cmt_i | input | NT | Commit unblock pulse per thread |
| cmt_sq_i | input | NT | Commit redirect valid per thread |
| cmt_pc_i | input | NT*AW | Commit redirect targets, thread t in bits [t*AW +: AW] |
| rob_sq_i | input | NT | Reorder buffer still squashing, per thread |
| dec_sq_i | input | NT | Decode redirect valid per thread |
| dec_pc_i | input | NT*AW | Decode redirect targets, thread t in bits [t*AW +: AW] |
| req_issue_i | input | NT | Cache request accepted |
| req_nack_i | input | NT | Cache request refused |
| retry_ok_i | input | NT | Refused request accepted on retry |
| resp_done_i | input | NT | Cache response arrived |
| fetch_opp_i | input | NT | Fetch opportunity for the thread |
| quiesce_i | input | NT | Quiesce instruction seen |
| fault_i | input | NT | Translation fault seen |
| wake_i | input | NT | Wake event |
| thr_state_o | output | NT*4 | State codes, thread t in bits [t*4 +: 4] |
| pc_o | output | NT*AW | Fetch PC per thread |
| npc_o | output | NT*AW | Next PC per thread |
| st_chg_o | output | 1 | Some thread changed state at the last edge |
| stage_active_o | output | 1 | Fetch stage has work |

## Verification
A wrong priority or a wrong stall flag shows on `thr_state_o` one edge after the inputs that exposed it. Examples are a decode redirect beating a commit redirect, or a flag that forgets a pulse. A lost or spurious redirect shows on `pc_o` and `npc_o` in that same cycle. Errors in the summary logic are visible on `st_chg_o` and `stage_active_o` with the same one-cycle delay, because both flags are formed from the state the threads enter. Each stimulus step therefore predicts the complete output vector for the next cycle. The sequence walks one thread through every transition, and a second thread is used to test independence and the active mask.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

   localparam int unsigned ST_W  = 4;
   localparam int unsigned N_SRC = 4;   // decode, rename, execute, commit

   typedef enum logic [ST_W-1:0] {
      ST_RUN      = 4'd0,
      ST_IDLE     = 4'd1,
      ST_SQUASH   = 4'd2,
      ST_BLOCKED  = 4'd3,
      ST_TRAP_PND = 4'd4,
      ST_QUI_PND  = 4'd5,
      ST_RETRY    = 4'd6,
      ST_WAIT_RSP = 4'd7,
      ST_ACC_DONE = 4'd8
   } fsq_state_t;

   function automatic logic fsq_is_busy(fsq_state_t s);
      return (s == ST_RUN) || (s == ST_SQUASH) || (s == ST_ACC_DONE);
   endfunction

endpackage

// File: rtl/fsq_stall_track.sv
module fsq_stall_track #(
   parameter int unsigned NT    = 2,
   parameter int unsigned NSRC  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NSRC-1:0][NT-1:0]   blk,
   input  logic [NSRC-1:0][NT-1:0]   unblk,
   output logic [NT-1:0]             stall_nxt
);

   logic [NSRC-1:0][NT-1:0] flag_q;
   logic [NSRC-1:0][NT-1:0] flag_d;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      for (genvar t = 0; t < NT; t++) begin : g_thr
         always_comb begin
            if (blk[s][t])
               flag_d[s][t] = 1'b1;
            else if (unblk[s][t])
               flag_d[s][t] = 1'b0;
            else
               flag_d[s][t] = flag_q[s][t];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= '0;
      else
         flag_q <= flag_d;
   end

   always_comb begin
      stall_nxt = '0;
      for (int s = 0; s < NSRC; s++)
         stall_nxt = stall_nxt | flag_d[s];
   end

endmodule

// File: rtl/fsq_thread_ctl.sv
module fsq_thread_ctl
   import fsq_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned INST_BYTES = 4,
   parameter logic [AW-1:0] RESET_PC = '0,
   parameter bit          NPC_REG    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmt_vld,
   input  logic [AW-1:0]   cmt_pc,
   input  logic            rob_sq,
   input  logic            dec_vld,
   input  logic [AW-1:0]   dec_pc,
   input  logic            stall,
   input  logic            ev_issue,
   input  logic            ev_nack,
   input  logic            ev_retry_ok,
   input  logic            ev_resp,
   input  logic            ev_fetch,
   input  logic            ev_quiesce,
   input  logic            ev_fault,
   input  logic            ev_wake,
   output fsq_state_t      st_q,
   output fsq_state_t      st_d,
   output logic [AW-1:0]   pc,
   output logic [AW-1:0]   npc
);

   localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

   logic [AW-1:0] pc_q;
   logic          redir;
   logic [AW-1:0] tgt;
   logic          stall_exempt;

   assign stall_exempt = (st_q == ST_WAIT_RSP) || (st_q == ST_QUI_PND) ||
                         (st_q == ST_TRAP_PND);

   always_comb begin
      st_d  = st_q;
      redir = 1'b0;
      tgt   = pc_q;
      if (cmt_vld) begin
         redir = 1'b1;
         tgt   = cmt_pc;
         st_d  = ST_SQUASH;
      end else if (rob_sq) begin
         st_d  = ST_SQUASH;
      end else if (dec_vld && (st_q != ST_SQUASH)) begin
         redir = 1'b1;
         tgt   = dec_pc;
         st_d  = ST_SQUASH;
      end else if (stall && !stall_exempt) begin
         st_d  = ST_BLOCKED;
      end else if ((st_q == ST_BLOCKED) || (st_q == ST_SQUASH)) begin
         st_d  = ST_RUN;
      end else begin
         case (st_q)
            ST_RUN: begin
               if (ev_quiesce)     st_d = ST_QUI_PND;
               else if (ev_fault)  st_d = ST_TRAP_PND;
               else if (ev_issue)  st_d = ST_WAIT_RSP;
               else if (ev_nack)   st_d = ST_RETRY;
            end
            ST_RETRY:    if (ev_retry_ok) st_d = ST_WAIT_RSP;
            ST_WAIT_RSP: if (ev_resp) st_d = stall ? ST_BLOCKED : ST_ACC_DONE;
            ST_ACC_DONE: if (ev_fetch) st_d = ST_RUN;
            ST_QUI_PND,
            ST_TRAP_PND: if (ev_wake) st_d = ST_RUN;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_RUN;
         pc_q <= RESET_PC;
      end else begin
         st_q <= st_d;
         if (redir)
            pc_q <= tgt;
      end
   end

   assign pc = pc_q;

   if (NPC_REG) begin : g_npc_reg
      logic [AW-1:0] npc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            npc_q <= RESET_PC + STEP;
         else if (redir)
            npc_q <= tgt + STEP;
      end
      assign npc = npc_q;
   end else begin : g_npc_add
      assign npc = pc_q + STEP;
   end

endmodule

// File: rtl/fsq_activity.sv
module fsq_activity
   import fsq_pkg::*;
#(
   parameter int unsigned NT = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NT-1:0]          thr_active,
   input  fsq_state_t [NT-1:0]    st_q,
   input  fsq_state_t [NT-1:0]    st_d,
   output logic                   chg,
   output logic                   act
);

   logic [NT-1:0] moved;
   logic [NT-1:0] busy;

   for (genvar t = 0; t < NT; t++) begin : g_thr
      assign moved[t] = (st_d[t] != st_q[t]);
      assign busy[t]  = thr_active[t] && fsq_is_busy(st_d[t]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chg <= 1'b0;
         act <= 1'b0;
      end else begin
         chg <= |moved;
         act <= |busy;
      end
   end

endmodule

// File: rtl/thread_fetch_seq.sv
module thread_fetch_seq
   import fsq_pkg::*;
#(
   parameter int unsigned   NT         = 2,
   parameter int unsigned   AW         = 32,
   parameter int unsigned   INST_BYTES = 4,
   parameter logic [AW-1:0] RESET_PC   = AW'(32'h0000_1000),
   parameter bit            NPC_REG    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NT-1:0]        thr_active_i,
   input  logic [NT-1:0]        blk_dec_i,
   input  logic [NT-1:0]        unblk_dec_i,
   input  logic [NT-1:0]        blk_ren_i,
   input  logic [NT-1:0]        unblk_ren_i,
   input  logic [NT-1:0]        blk_exe_i,
   input  logic [NT-1:0]        unblk_exe_i,
   input  logic [NT-1:0]        blk_cmt_i,
   input  logic [NT-1:0]        unblk_cmt_i,
   input  logic [NT-1:0]        cmt_sq_i,
   input  logic [NT*AW-1:0]     cmt_pc_i,
   input  logic [NT-1:0]        rob_sq_i,
   input  logic [NT-1:0]        dec_sq_i,
   input  logic [NT*AW-1:0]     dec_pc_i,
   input  logic [NT-1:0]        req_issue_i,
   input  logic [NT-1:0]        req_nack_i,
   input  logic [NT-1:0]        retry_ok_i,
   input  logic [NT-1:0]        resp_done_i,
   input  logic [NT-1:0]        fetch_opp_i,
   input  logic [NT-1:0]        quiesce_i,
   input  logic [NT-1:0]        fault_i,
   input  logic [NT-1:0]        wake_i,
   output logic [NT*ST_W-1:0]   thr_state_o,
   output logic [NT*AW-1:0]     pc_o,
   output logic [NT*AW-1:0]     npc_o,
   output logic                 st_chg_o,
   output logic                 stage_active_o
);

   if (NT < 1) begin : g_bad_nt
      $error("thread_fetch_seq: NT must be at least 1");
   end
   if (AW < 8) begin : g_bad_aw
      $error("thread_fetch_seq: AW must be at least 8");
   end
   if ((INST_BYTES == 0) || ((INST_BYTES & (INST_BYTES - 1)) != 0)) begin : g_bad_ib
      $error("thread_fetch_seq: INST_BYTES must be a power of two");
   end

   logic [N_SRC-1:0][NT-1:0] blk_v;
   logic [N_SRC-1:0][NT-1:0] unblk_v;
   logic [NT-1:0]            stall_nxt;
   fsq_state_t [NT-1:0]      st_q;
   fsq_state_t [NT-1:0]      st_d;

   assign blk_v   = {blk_cmt_i,   blk_exe_i,   blk_ren_i,   blk_dec_i};
   assign unblk_v = {unblk_cmt_i, unblk_exe_i, unblk_ren_i, unblk_dec_i};

   fsq_stall_track #(.NT(NT), .NSRC(N_SRC)) u_stall (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk       (blk_v),
      .unblk     (unblk_v),
      .stall_nxt (stall_nxt)
   );

   for (genvar t = 0; t < NT; t++) begin : g_thr
      fsq_thread_ctl #(
         .AW(AW), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC), .NPC_REG(NPC_REG)
      ) u_ctl (
         .clk         (clk),
         .rst_n       (rst_n),
         .cmt_vld     (cmt_sq_i[t]),
         .cmt_pc      (cmt_pc_i[t*AW +: AW]),
         .rob_sq      (rob_sq_i[t]),
         .dec_vld     (dec_sq_i[t]),
         .dec_pc      (dec_pc_i[t*AW +: AW]),
         .stall       (stall_nxt[t]),
         .ev_issue    (req_issue_i[t]),
         .ev_nack     (req_nack_i[t]),
         .ev_retry_ok (retry_ok_i[t]),
         .ev_resp     (resp_done_i[t]),
         .ev_fetch    (fetch_opp_i[t]),
         .ev_quiesce  (quiesce_i[t]),
         .ev_fault    (fault_i[t]),
         .ev_wake     (wake_i[t]),
         .st_q        (st_q[t]),
         .st_d        (st_d[t]),
         .pc          (pc_o[t*AW +: AW]),
         .npc         (npc_o[t*AW +: AW])
      );
      assign thr_state_o[t*ST_W +: ST_W] = st_q[t];
   end

   fsq_activity #(.NT(NT)) u_act (
      .clk        (clk),
      .rst_n      (rst_n),
      .thr_active (thr_active_i),
      .st_q       (st_q),
      .st_d       (st_d),
      .chg        (st_chg_o),
      .act        (stage_active_o)
   );

endmodule

// File: rtl/fsq_chk.sv
module fsq_chk #(
   parameter int unsigned NT         = 2,
   parameter int unsigned AW         = 32,
   parameter int unsigned INST_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NT-1:0]     cmt_sq_i,
   input logic [NT*AW-1:0]  cmt_pc_i,
   input logic [NT-1:0]     rob_sq_i,
   input logic [NT-1:0]     dec_sq_i,
   input logic [NT-1:0]     resp_done_i,
   input logic [NT-1:0]     wake_i,
   input logic [NT*4-1:0]   thr_state_o,
   input logic [NT*AW-1:0]  pc_o,
   input logic [NT*AW-1:0]  npc_o,
   input logic              st_chg_o
);

   // R11
   chg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (st_chg_o == (thr_state_o != $past(thr_state_o))));

   for (genvar t = 0; t < NT; t++) begin : g_thr
      // R4
      cmt_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cmt_sq_i[t] |=> (thr_state_o[t*4 +: 4] == 4'd2) &&
                         (pc_o[t*AW +: AW] == $past(cmt_pc_i[t*AW +: AW])));

      // R4
      npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |-> (npc_o[t*AW +: AW] == pc_o[t*AW +: AW] + AW'(INST_BYTES)));

      // R6
      dec_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_sq_i[t] && !cmt_sq_i[t] && !rob_sq_i[t] &&
          thr_state_o[t*4 +: 4] == 4'd2) |=> $stable(pc_o[t*AW +: AW]));

      // R7
      squash_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (thr_state_o[t*4 +: 4] == 4'd2 && !cmt_sq_i[t] && !rob_sq_i[t] &&
          !dec_sq_i[t]) |=> (thr_state_o[t*4 +: 4] != 4'd2));

      // R8
      wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (thr_state_o[t*4 +: 4] == 4'd7 && !resp_done_i[t] && !cmt_sq_i[t] &&
          !rob_sq_i[t] && !dec_sq_i[t]) |=> (thr_state_o[t*4 +: 4] == 4'd7));

      // R10
      quiesce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (thr_state_o[t*4 +: 4] == 4'd5 && !wake_i[t] && !cmt_sq_i[t] &&
          !rob_sq_i[t] && !dec_sq_i[t]) |=> (thr_state_o[t*4 +: 4] == 4'd5));
   end

endmodule

bind thread_fetch_seq fsq_chk #(.NT(NT), .AW(AW), .INST_BYTES(INST_BYTES)) u_chk (.*);

// File: tb/sim_thread_fetch_seq.sv
`timescale 1ns/1ps
module sim_thread_fetch_seq;

   localparam int NT = 2;
   localparam int AW = 32;

   typedef struct {
      string       tag;
      logic [3:0]  s0, s1;
      logic [31:0] pc0, npc0, pc1;
      logic        chg, act;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NT-1:0] thr_active, blk_dec, unblk_dec, blk_ren, unblk_ren, blk_exe, unblk_exe;
   logic [NT-1:0] blk_cmt, unblk_cmt, cmt_sq, rob_sq, dec_sq, req_issue, req_nack;
   logic [NT-1:0] retry_ok, resp_done, fetch_opp, quiesce, fault, wake;
   logic [NT*AW-1:0] cmt_pc, dec_pc;
   logic [NT*4-1:0]  thr_state;
   logic [NT*AW-1:0] pc, npc;
   logic st_chg, stage_active;

   int compared = 0;
   int mismatched = 0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   thread_fetch_seq u0 (
      .clk(clk), .rst_n(rst_n), .thr_active_i(thr_active),
      .blk_dec_i(blk_dec), .unblk_dec_i(unblk_dec), .blk_ren_i(blk_ren), .unblk_ren_i(unblk_ren),
      .blk_exe_i(blk_exe), .unblk_exe_i(unblk_exe), .blk_cmt_i(blk_cmt), .unblk_cmt_i(unblk_cmt),
      .cmt_sq_i(cmt_sq), .cmt_pc_i(cmt_pc), .rob_sq_i(rob_sq), .dec_sq_i(dec_sq), .dec_pc_i(dec_pc),
      .req_issue_i(req_issue), .req_nack_i(req_nack), .retry_ok_i(retry_ok), .resp_done_i(resp_done),
      .fetch_opp_i(fetch_opp), .quiesce_i(quiesce), .fault_i(fault), .wake_i(wake),
      .thr_state_o(thr_state), .pc_o(pc), .npc_o(npc), .st_chg_o(st_chg), .stage_active_o(stage_active)
   );

   task automatic compare(exp_t e);
      compared++;
      if (thr_state[3:0] !== e.s0 || thr_state[7:4] !== e.s1 || pc[31:0] !== e.pc0 ||
          npc[31:0] !== e.npc0 || pc[63:32] !== e.pc1 || st_chg !== e.chg ||
          stage_active !== e.act) begin
         mismatched++;
         $display("FAIL %s: actual s0=%0d s1=%0d pc0=%h npc0=%h pc1=%h chg=%b act=%b expected s0=%0d s1=%0d pc0=%h npc0=%h pc1=%h chg=%b act=%b",
                  e.tag, thr_state[3:0], thr_state[7:4], pc[31:0], npc[31:0], pc[63:32], st_chg,
                  stage_active, e.s0, e.s1, e.pc0, e.npc0, e.pc1, e.chg, e.act);
      end
   endtask

   // monitor: one expected item per clock edge, sampled 1 ns after it
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) compare(q.pop_front());
      end
   end

   task automatic clr();
      {blk_dec, unblk_dec, blk_ren, unblk_ren, blk_exe, unblk_exe, blk_cmt, unblk_cmt} = '0;
      {cmt_sq, rob_sq, dec_sq, req_issue, req_nack, retry_ok, resp_done} = '0;
      {fetch_opp, quiesce, fault, wake} = '0;
      cmt_pc = '0;
      dec_pc = '0;
   endtask

   // driver: inputs are already set; push the prediction for the next edge
   task automatic cyc(string tag, logic [3:0] s0, logic [3:0] s1, logic [31:0] p0,
                      logic [31:0] p1, logic chg, logic act);
      exp_t e;
      e.tag = tag; e.s0 = s0; e.s1 = s1; e.pc0 = p0; e.npc0 = p0 + 32'd4;
      e.pc1 = p1; e.chg = chg; e.act = act;
      q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      clr();
   endtask

   initial begin
      #(200000 * 5);
      mismatched++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      exp_t r;
      clr();
      thr_active = 2'b01;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      r.tag = "R1 reset"; r.s0 = 4'd0; r.s1 = 4'd0; r.pc0 = 32'h1000; r.npc0 = 32'h1004;
      r.pc1 = 32'h1000; r.chg = 1'b0; r.act = 1'b0;
      compare(r);

      cyc("R12 active running", 0, 0, 32'h1000, 32'h1000, 0, 1);
      thr_active = 2'b00;
      cyc("R12 mask clear", 0, 0, 32'h1000, 32'h1000, 0, 0);
      thr_active = 2'b01;
      blk_dec[0] = 1'b1;
      cyc("R2 block sets", 3, 0, 32'h1000, 32'h1000, 1, 0);
      cyc("R2 flag sticky", 3, 0, 32'h1000, 32'h1000, 0, 0);
      blk_exe[0] = 1'b1;
      cyc("R3 second flag", 3, 0, 32'h1000, 32'h1000, 0, 0);
      unblk_dec[0] = 1'b1;
      cyc("R3 one flag left", 3, 0, 32'h1000, 32'h1000, 0, 0);
      unblk_exe[0] = 1'b1;
      cyc("R2 all released", 0, 0, 32'h1000, 32'h1000, 1, 1);
      cmt_sq[0] = 1'b1; cmt_pc[31:0] = 32'h2000;
      dec_sq[0] = 1'b1; dec_pc[31:0] = 32'h3000; rob_sq[0] = 1'b1;
      cyc("R4 commit wins", 2, 0, 32'h2000, 32'h1000, 1, 1);
      dec_sq[0] = 1'b1; dec_pc[31:0] = 32'h3000;
      cyc("R6 decode ignored while squashing", 0, 0, 32'h2000, 32'h1000, 1, 1);
      dec_sq[0] = 1'b1; dec_pc[31:0] = 32'h3000;
      cyc("R6 decode redirect", 2, 0, 32'h3000, 32'h1000, 1, 1);
      cyc("R7 squash one cycle", 0, 0, 32'h3000, 32'h1000, 1, 1);
      rob_sq[0] = 1'b1;
      cyc("R5 rob squash", 2, 0, 32'h3000, 32'h1000, 1, 1);
      rob_sq[0] = 1'b1;
      cyc("R5 rob squash held", 2, 0, 32'h3000, 32'h1000, 0, 1);
      blk_ren[0] = 1'b1;
      cyc("R7 squash to blocked", 3, 0, 32'h3000, 32'h1000, 1, 0);
      unblk_ren[0] = 1'b1;
      cyc("R2 rename release", 0, 0, 32'h3000, 32'h1000, 1, 1);
      req_issue[0] = 1'b1;
      cyc("R9 issue", 7, 0, 32'h3000, 32'h1000, 1, 0);
      blk_cmt[0] = 1'b1;
      cyc("R8 wait ignores stall", 7, 0, 32'h3000, 32'h1000, 0, 0);
      resp_done[0] = 1'b1;
      cyc("R8 response while stalled", 3, 0, 32'h3000, 32'h1000, 1, 0);
      unblk_cmt[0] = 1'b1;
      cyc("R2 commit release", 0, 0, 32'h3000, 32'h1000, 1, 1);
      req_issue[0] = 1'b1;
      cyc("R9 issue again", 7, 0, 32'h3000, 32'h1000, 1, 0);
      resp_done[0] = 1'b1;
      cyc("R8 access complete", 8, 0, 32'h3000, 32'h1000, 1, 1);
      cyc("R8 complete holds", 8, 0, 32'h3000, 32'h1000, 0, 1);
      fetch_opp[0] = 1'b1;
      cyc("R8 fetch opportunity", 0, 0, 32'h3000, 32'h1000, 1, 1);
      req_nack[0] = 1'b1;
      cyc("R9 refused", 6, 0, 32'h3000, 32'h1000, 1, 0);
      retry_ok[0] = 1'b1;
      cyc("R9 retry accepted", 7, 0, 32'h3000, 32'h1000, 1, 0);
      cmt_sq[0] = 1'b1; cmt_pc[31:0] = 32'h4000;
      cyc("R4 commit while waiting", 2, 0, 32'h4000, 32'h1000, 1, 1);
      cyc("R7 back to running", 0, 0, 32'h4000, 32'h1000, 1, 1);
      quiesce[0] = 1'b1;
      cyc("R10 quiesce", 5, 0, 32'h4000, 32'h1000, 1, 0);
      blk_dec[0] = 1'b1;
      cyc("R10 quiesce ignores stall", 5, 0, 32'h4000, 32'h1000, 0, 0);
      wake[0] = 1'b1;
      cyc("R10 wake", 0, 0, 32'h4000, 32'h1000, 1, 1);
      cyc("R2 flag still set after wake", 3, 0, 32'h4000, 32'h1000, 1, 0);
      unblk_dec[0] = 1'b1;
      cyc("R2 decode release", 0, 0, 32'h4000, 32'h1000, 1, 1);
      fault[0] = 1'b1;
      cyc("R10 fault", 4, 0, 32'h4000, 32'h1000, 1, 0);
      cyc("R10 trap holds", 4, 0, 32'h4000, 32'h1000, 0, 0);
      dec_sq[0] = 1'b1; dec_pc[31:0] = 32'h5000;
      cyc("R10 squash leaves trap", 2, 0, 32'h5000, 32'h1000, 1, 1);
      cyc("R7 running", 0, 0, 32'h5000, 32'h1000, 1, 1);
      cmt_sq[1] = 1'b1; cmt_pc[63:32] = 32'h6000;
      cyc("R4 thread1 commit", 0, 2, 32'h5000, 32'h6000, 1, 1);
      thr_active = 2'b10;
      cyc("R12 thread1 only", 0, 0, 32'h5000, 32'h6000, 1, 1);
      blk_dec[1] = 1'b1;
      cyc("R12 thread1 blocked", 0, 3, 32'h5000, 32'h6000, 1, 0);
      cyc("R11 no change", 0, 3, 32'h5000, 32'h6000, 0, 0);

      #10;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule